// File: doc/BRIEF.md
# Maskable Edge-Capture Interrupt Controller

The controller collects twelve request sources onto a single processor interrupt line. Four sources are external port pins. Eight are internal peripheral events such as a prescaler tick, a counter reaching zero or matching its compare value, a storage write finishing, a conversion finishing and a voltage measurement finishing. Each source has its own mask bit. A source sets its request flag on a rising edge, and only while its mask bit is 1. An edge that arrives while the mask bit is 0 is lost.

The twelve flags are grouped into three 4-bit request registers, and each group has a matching mask register. Reading a request register returns its flags and clears them. Writing a 1 to a flag position clears only that flag. The interrupt line is the OR of all flags, gated by a global enable bit. A serial-buffer-empty request ignores the masks and the global enable and drives the line directly. Software decides which request to service first. The hardware applies no priority.

Top module: `irq_capture_ctrl`

## Requirements
- R1: Source k maps to request register address k/4, bit k%4. Sources 0..3 are `ext_req_i[3:0]` and sources 4..11 are `int_req_i[7:0]`.
- R2: A rising edge on an internal source with its mask bit set appears as a flag in the request register read after the next rising clock edge.
- R3: An external pin passes through a two-flop synchronizer. Its flag appears after the third rising clock edge that follows the pin change, and is not visible after the second.
- R4: An edge that arrives while the mask bit is 0 is not stored. A level still held high when the mask is later set does not set the flag.
- R5: `irq_o` = (global enable AND any flag) OR `buf_empty_i`. The global enable is bit 0 of the control register at address 6, and that address reads back {3'b000, enable}.
- R6: `buf_empty_i` drives `irq_o` high in the same cycle, whatever the masks, flags and global enable.
- R7: Reset clears all masks, all flags and the global enable. Every address then reads 0, and `irq_o` is low while `buf_empty_i` is low.
- R8: A read (`rd_en_i`) at address 0, 1 or 2 returns that register's flags in the same cycle and clears them all at the clock edge.
- R9: A write at address 0, 1 or 2 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R10: If a qualifying edge and a read-clear or write-clear of the same flag fall in the same cycle, the flag ends up set.
- R11: The mask registers sit at addresses 3, 4 and 5, for groups 0, 1 and 2. Reading them has no side effect. Address 7 reads 0.
- R12: A new edge after the flags were read and cleared is captured and drives `irq_o` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | 4 | External port pin requests (asynchronous) |
| int_req_i | input | 8 | Internal peripheral event requests (synchronous) |
| buf_empty_i | input | 1 | Unmaskable serial-buffer-empty request |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe; clears the addressed request register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 4 | Write data |
| rd_data_o | output | 4 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
Read data and `irq_o` are combinational from the state and from `buf_empty_i`, so they are due in the same cycle as their cause. An internal edge or a register access takes effect one clock edge later. An external pin takes effect three clock edges later. The bench drives on the falling edge and samples 1 ns after it. Each expected value comes from a behavioural model updated at each rising edge, which keeps input histories so that it can apply the one-edge and three-edge delays. The directed checks count edges in the same way: the external-pin check looks once after the second edge and once after the third.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SYS_EN_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_REQ,
    SEL_MASK,
    SEL_SYS
  } sel_kind_e;

  // request regs at 0..n-1, masks at n..2n-1, control at 2n
  function automatic sel_kind_e decode_kind(input int unsigned addr, input int unsigned n_grp);
    if (addr < n_grp) return SEL_REQ;
    if (addr < 2 * n_grp) return SEL_MASK;
    if (addr == 2 * n_grp) return SEL_SYS;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rise_o
);
  logic cur;
  logic prev_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
      end else begin
        sync_q[0] <= req_i;
        for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
    end
    assign cur = sync_q[SYNC_STAGES-1];
  end else begin : g_direct
    assign cur = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign rise_o = cur & ~prev_q;
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      // capture after clear so a coincident edge survives
      flag_q <= (flag_q & ~clr_i) | (rise_i & mask_q);
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT       = 4,
  parameter int N_INT       = 8,
  parameter int GRP_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              buf_empty_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [GRP_W-1:0]  wr_data_i,
  output logic [GRP_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int N_SRC = N_EXT + N_INT;
  localparam int N_GRP = (N_SRC + GRP_W - 1) / GRP_W;
  localparam int N_PAD = N_GRP * GRP_W;

  logic [N_SRC-1:0] rise;
  logic [N_PAD-1:0] rise_pad;
  logic [N_PAD-1:0] flag_q;
  logic [N_PAD-1:0] mask_q;
  logic             gen_en_q;
  sel_kind_e        kind;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    irq_src_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (ext_req_i[i]),
      .rise_o(rise[i])
    );
  end

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    irq_src_edge #(.SYNC_STAGES(0)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (int_req_i[i]),
      .rise_o(rise[N_EXT+i])
    );
  end

  assign rise_pad = N_PAD'(rise);
  assign kind     = decode_kind(32'(addr_i), N_GRP);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic             sel_req, sel_mask;
    logic [GRP_W-1:0] clr;

    assign sel_req  = (kind == SEL_REQ)  && (addr_i == ADDR_W'(g));
    assign sel_mask = (kind == SEL_MASK) && (addr_i == ADDR_W'(N_GRP + g));

    always_comb begin
      clr = '0;
      if (sel_req && rd_en_i)      clr = '1;
      else if (sel_req && wr_en_i) clr = wr_data_i;
    end

    irq_flag_group #(.W(GRP_W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rise_i   (rise_pad[g*GRP_W +: GRP_W]),
      .clr_i    (clr),
      .mask_we_i(sel_mask && wr_en_i),
      .mask_wd_i(wr_data_i),
      .flag_o   (flag_q[g*GRP_W +: GRP_W]),
      .mask_o   (mask_q[g*GRP_W +: GRP_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gen_en_q <= 1'b0;
    else if (wr_en_i && kind == SEL_SYS)  gen_en_q <= wr_data_i[SYS_EN_BIT];
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (kind == SEL_REQ && addr_i == ADDR_W'(g))
        rd_data_o = flag_q[g*GRP_W +: GRP_W];
      if (kind == SEL_MASK && addr_i == ADDR_W'(N_GRP + g))
        rd_data_o = mask_q[g*GRP_W +: GRP_W];
    end
    if (kind == SEL_SYS) rd_data_o[SYS_EN_BIT] = gen_en_q;
  end

  assign irq_o = (gen_en_q & (|flag_q)) | buf_empty_i;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int GRP_W  = 4,
  parameter int N_GRP  = 3,
  parameter int ADDR_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_GRP*GRP_W-1:0]  flag_i,
  input logic [N_GRP*GRP_W-1:0]  mask_i,
  input logic [N_GRP*GRP_W-1:0]  rise_i,
  input logic                    gen_en_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    rd_en_i,
  input logic                    wr_en_i,
  input logic [GRP_W-1:0]        wr_data_i,
  input logic                    buf_empty_i,
  input logic                    irq_o
);
  localparam int N_BIT = N_GRP * GRP_W;

  // R7: state held cleared while reset is active
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r7_reset_state: assert (flag_i == '0 && mask_i == '0 && !gen_en_i)
        else $error("reset state not clear");
    end
  end

  a_r6_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_empty_i |-> irq_o);

  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_en_i && !buf_empty_i) |-> !irq_o);

  for (genvar i = 0; i < N_BIT; i++) begin : g_bit
    localparam int G = i / GRP_W;
    localparam int B = i % GRP_W;

    a_r4_set_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[i]) |-> $past(mask_i[i]));

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i[i] && mask_i[i]) |=> flag_i[i]);

    a_r9_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && wr_en_i && !rd_en_i && addr_i == ADDR_W'(G) && !wr_data_i[B])
      |=> flag_i[i]);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_W'(g) && !(|(rise_i[g*GRP_W +: GRP_W] & mask_i[g*GRP_W +: GRP_W])))
      |=> flag_i[g*GRP_W +: GRP_W] == '0);
  end
endmodule

bind irq_capture_ctrl irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flag_i     (flag_q),
  .mask_i     (mask_q),
  .rise_i     (rise_pad),
  .gen_en_i   (gen_en_q),
  .addr_i     (addr_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .buf_empty_i(buf_empty_i),
  .irq_o      (irq_o)
);

// File: tb/tb_irq_capture_ctrl.sv
`timescale 1ns/1ps
module tb_irq_capture_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [3:0] ext_req = '0;
  logic [7:0] int_req = '0;
  logic       buf_empty = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rd_data;
  logic       irq;

  int total = 0, bad = 0;
  string cur_req = "R7";

  always #2.5 clk = ~clk;

  irq_capture_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_req_i(ext_req), .int_req_i(int_req),
    .buf_empty_i(buf_empty), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference model
  bit [11:0] m_flag, m_mask;
  bit        m_en;
  bit [3:0]  eq[$];
  bit [7:0]  iq[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag = '0; m_mask = '0; m_en = 1'b0;
      eq.delete(); iq.delete();
    end else begin
      bit [3:0]  e_new, e_old;
      bit [7:0]  i_new, i_old;
      bit [11:0] rise, clr;
      int n;
      eq.push_back(ext_req);
      iq.push_back(int_req);
      n = eq.size();
      e_new = (n >= 3) ? eq[n-3] : 4'h0;   // pin value two edges back
      e_old = (n >= 4) ? eq[n-4] : 4'h0;
      n = iq.size();
      i_new = iq[n-1];
      i_old = (n >= 2) ? iq[n-2] : 8'h0;
      rise = {i_new & ~i_old, e_new & ~e_old};
      clr = '0;
      if (rd_en && addr < 3)      clr[addr*4 +: 4] = 4'hF;
      else if (wr_en && addr < 3) clr[addr*4 +: 4] = wdata;
      m_flag = (m_flag & ~clr) | (rise & m_mask);
      if (wr_en && addr >= 3 && addr <= 5) m_mask[(addr-3)*4 +: 4] = wdata;
      if (wr_en && addr == 6) m_en = wdata[0];
      while (eq.size() > 4) void'(eq.pop_front());
      while (iq.size() > 2) void'(iq.pop_front());
    end
  end

  function automatic bit [3:0] exp_rd(input bit [2:0] a);
    if (a < 3) return m_flag[a*4 +: 4];
    if (a < 6) return m_mask[(a-3)*4 +: 4];
    if (a == 6) return {3'b000, m_en};
    return 4'h0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      chk({cur_req, " model irq"}, int'(irq), int'((m_en & (|m_flag)) | buf_empty));
      chk({cur_req, " model rd_data"}, int'(rd_data), int'(exp_rd(addr)));
    end
  end

  task automatic peek(input bit [2:0] a, input bit [3:0] e, input string tag);
    addr = a;
    #1 chk(tag, int'(rd_data), int'(e));
  endtask

  task automatic cirq(input bit e, input string tag);
    #1 chk(tag, int'(irq), int'(e));
  endtask

  task automatic wr(input bit [2:0] a, input bit [3:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdclr(input bit [2:0] a, output bit [3:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [3:0] v;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7: everything clear after reset
    cur_req = "R7";
    for (int a = 0; a < 8; a++) peek(3'(a), 4'h0, "R7 reset read");
    cirq(1'b0, "R7 reset irq");

    // R4: edge while masked is dropped, held level does not set later
    cur_req = "R4";
    @(negedge clk); int_req[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(3'd1, 4'h0, "R4 masked edge");
    wr(3'd4, 4'hF);
    @(negedge clk); @(negedge clk);
    peek(3'd1, 4'h0, "R4 held level");
    // R2: edge with mask set, visible after one clock edge
    cur_req = "R2";
    int_req[0] = 1'b0;
    @(negedge clk); int_req[0] = 1'b1;
    @(negedge clk);
    peek(3'd1, 4'h1, "R2 internal capture");
    int_req[0] = 1'b0;

    // R5: global enable gating
    cur_req = "R5";
    cirq(1'b0, "R5 enable off");
    wr(3'd6, 4'h1);
    cirq(1'b1, "R5 enable on");
    peek(3'd6, 4'h1, "R5 control readback");

    // R8: read returns then clears
    cur_req = "R8";
    rdclr(3'd1, v);
    chk("R8 read value", int'(v), 1);
    peek(3'd1, 4'h0, "R8 cleared");
    cirq(1'b0, "R8 irq drops");

    // R3: external pin through synchronizer
    cur_req = "R3";
    wr(3'd3, 4'hF);
    @(negedge clk); ext_req[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(3'd0, 4'h0, "R3 not after two edges");
    @(negedge clk);
    peek(3'd0, 4'h4, "R3 after three edges");
    cirq(1'b1, "R3 irq");
    ext_req[2] = 1'b0;
    rdclr(3'd0, v);

    // R9: write-one clears single flags
    cur_req = "R9";
    wr(3'd5, 4'hF);
    @(negedge clk); int_req[7:4] = 4'hF;
    @(negedge clk);
    peek(3'd2, 4'hF, "R9 setup");
    wr(3'd2, 4'b0101);
    peek(3'd2, 4'b1010, "R9 w1c");
    wr(3'd2, 4'h0);
    peek(3'd2, 4'b1010, "R9 zero write");
    int_req[7:4] = 4'h0;
    rdclr(3'd2, v);

    // R10: set wins over clear in the same cycle
    cur_req = "R10";
    @(negedge clk); int_req[1] = 1'b1; addr = 3'd1; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    peek(3'd1, 4'h2, "R10 set beats read");
    int_req[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); int_req[1] = 1'b1; addr = 3'd1; wdata = 4'hF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    peek(3'd1, 4'h2, "R10 set beats write");
    int_req[1] = 1'b0;
    rdclr(3'd1, v);

    // R6: unmaskable buffer-empty bypass
    cur_req = "R6";
    wr(3'd6, 4'h0);
    @(negedge clk); int_req[2] = 1'b1;
    @(negedge clk);
    peek(3'd1, 4'h4, "R6 flag pending");
    cirq(1'b0, "R6 pending but disabled");
    buf_empty = 1'b1;
    cirq(1'b1, "R6 bypass high");
    buf_empty = 1'b0;
    cirq(1'b0, "R6 bypass low");
    int_req[2] = 1'b0;
    rdclr(3'd1, v);

    // R11: mask readback without side effect
    cur_req = "R11";
    peek(3'd3, 4'hF, "R11 mask0");
    peek(3'd5, 4'hF, "R11 mask2");
    rdclr(3'd4, v);
    chk("R11 mask1 read", int'(v), 15);
    peek(3'd4, 4'hF, "R11 mask kept");
    peek(3'd7, 4'h0, "R11 unused addr");

    // R12: new request after service re-raises irq
    cur_req = "R12";
    wr(3'd6, 4'h1);
    @(negedge clk); int_req[3] = 1'b1;
    @(negedge clk);
    cirq(1'b1, "R12 first irq");
    rdclr(3'd1, v);
    chk("R12 serviced value", int'(v), 8);
    cirq(1'b0, "R12 after read");
    int_req[3] = 1'b0;
    @(negedge clk); int_req[3] = 1'b1;
    @(negedge clk);
    cirq(1'b1, "R12 irq again");
    peek(3'd1, 4'h8, "R12 flag again");
    int_req[3] = 1'b0;
    rdclr(3'd1, v);

    // R1: source to bit mapping
    cur_req = "R1";
    @(negedge clk); int_req[6] = 1'b1;
    @(negedge clk);
    peek(3'd2, 4'h4, "R1 source 10");
    int_req[6] = 1'b0;
    @(negedge clk); ext_req[1] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    peek(3'd0, 4'h2, "R1 source 1");
    ext_req[1] = 1'b0;
    rdclr(3'd0, v);
    rdclr(3'd2, v);

    // mixed traffic against the model
    cur_req = "R2/R3/R8/R9 mixed";
    for (int c = 0; c < 600; c++) begin
      int sel;
      @(negedge clk);
      ext_req   = 4'($urandom);
      int_req   = 8'($urandom);
      buf_empty = ($urandom % 8) == 0;
      sel       = $urandom % 4;
      addr      = 3'($urandom);
      wdata     = 4'($urandom);
      rd_en     = (sel == 0);
      wr_en     = (sel == 1);
    end
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; buf_empty = 1'b0;
    repeat (5) @(negedge clk);

    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule